// File: doc/BRIEF.md
# Dual Cascadable Interval Timers

The block holds two 16-bit down-counters, timer A and timer B. Each one has a reload latch and a control byte, and all of them sit behind a small byte-wide register bus. A running timer decrements on its selected tick. When it is at zero and ticks again, it reloads from its latch and raises a one-cycle underflow strobe. The strobes go to an interrupt controller, and timer A's strobe is also copied to a serial shifter. Neither of those two blocks is part of this design.

Timer A ticks on system clock cycles or on rising edges of an external count pin. Timer B ticks on clock cycles, on count-pin edges, or on timer A underflows, so the two timers can be chained into one 32-bit interval. Each timer can run continuously or as a one-shot, and it has a force-load strobe. Each timer can also replace one bit of an 8-bit port path with its output. That output is either a pulse that is high while the counter is zero, or a level that toggles on every underflow.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF, both control bytes are 0, both timers are stopped, and all strobes are low.
- R2: A read at address 4 or 5 returns the live low or high byte of counter A. Addresses 6 and 7 do the same for counter B. Addresses 14 and 15 return control A and control B. Control bit 4 always reads back as 0.
- R3: A write to the low latch byte (address 4 or 6) changes only the latch. A write to the high latch byte (address 5 or 7) while that timer's start bit is 0 also loads the full latch value into the counter.
- R4: A write that sets start bit 0 with counter value C makes the first underflow strobe rise C+1 cycles after the write edge. After that the period is latch+1 cycles. Each strobe lasts one cycle, and timer A's shifter strobe rises together with its interrupt strobe.
- R5: Writing control bit 4 loads the counter from the latch. If bit 4 is written in the same write that starts the timer, the first underflow comes one cycle later, at latch+2 cycles.
- R6: With control bit 3 set (one-shot), an underflow reloads the counter and clears start bit 0, and no further underflow follows.
- R7: Clearing start bit 0 without bit 4 decrements the counter once more, unless it is 0. A counter at 0 stays at 0 and no underflow occurs. Clearing start together with bit 4 leaves the counter at the latch value.
- R8: With control bit 2 set (toggle), the timer output is forced to 1 when start bit 0 goes from 0 to 1, and it inverts on every underflow.
- R9: With control bit 2 clear (pulse), the timer output is 1 exactly while the counter is 0.
- R10: When control bit 1 is set, the timer output replaces port bit 6 (timer A) or port bit 7 (timer B) on the way from port_i to port_o. When bit 1 is clear, the bit passes through unchanged.
- R11: Timer A control bit 5 = 1 makes it tick on rising edges of cnt_i. Timer B control bits 6:5 select its tick: 00 clock cycles, 01 or 11 rising edges of cnt_i, 10 timer A underflows. A timer that gets no ticks holds its count.
- R12: In cascade mode, timer B decrements once per timer A underflow. If it is already 0 on that underflow, it reloads and strobes instead, so with B's counter at 2 its strobe comes with the third A underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable (1 = write) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| cnt_i | input | 1 | External count pin, counted on rising edges |
| port_i | input | 8 | Port value before timer override |
| port_o | output | 8 | Port value with timer outputs merged into bits 6 and 7 |
| ta_uf_o | output | 1 | Timer A underflow strobe to interrupt logic |
| ta_shift_o | output | 1 | Timer A underflow strobe to the serial shifter |
| tb_uf_o | output | 1 | Timer B underflow strobe to interrupt logic |

## Verification
The bench counts exact cycles from the start write to the first strobe, with and without force-load. An off-by-one start or a missing extra cycle after force-load shows up as a wrong interval. The stop decrement is checked at counter values 100 and 0. A design without the extra decrement reads back 100 instead of 99, and one that ignores the zero guard wraps to 0xFFFF or fires a spurious strobe. Cascade mode checks that B strobes with exactly the third A underflow, which catches a counter that reloads at zero without strobing or that counts clock cycles. Separate checks make sure a high-byte write loads a stopped counter while a low-byte write does not, and that a one-shot timer stays silent once it has fired.

// File: rtl/dit_pkg.sv
package dit_pkg;
  // control byte fields
  localparam int CR_START   = 0;
  localparam int CR_PORT_EN = 1;
  localparam int CR_TOGGLE  = 2;
  localparam int CR_ONESHOT = 3;
  localparam int CR_FORCE   = 4;
  localparam int CR_SRC_LO  = 5;
  localparam int CR_SRC_HI  = 6;

  // register offsets
  localparam int REG_A_LO  = 4;
  localparam int REG_A_HI  = 5;
  localparam int REG_B_LO  = 6;
  localparam int REG_B_HI  = 7;
  localparam int REG_A_CTL = 14;
  localparam int REG_B_CTL = 15;

  typedef enum logic [1:0] {
    SRC_CLOCK,
    SRC_PIN,
    SRC_CASCADE
  } src_e;

  function automatic src_e b_src(input logic [1:0] sel);
    case (sel)
      2'b00:   return SRC_CLOCK;
      2'b10:   return SRC_CASCADE;
      default: return SRC_PIN;
    endcase
  endfunction
endpackage

// File: rtl/dit_edge_det.sv
module dit_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/dit_timer_core.sv
module dit_timer_core
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              lat_lo_we_i,
  input  logic              lat_hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  latch_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              uf_evt_o,
  output logic              uf_o,
  output logic              out_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lat_q, lat_d;
  logic              hold_q, tog_q, tog_d, uf_q;
  logic              run, force_ld, stop_wr, start_wr, active, zero, uf_evt;

  assign run      = ctrl_q[CR_START];
  assign force_ld = ctrl_we_i & wdata_i[CR_FORCE];
  assign stop_wr  = ctrl_we_i & run & ~wdata_i[CR_START];
  assign start_wr = ctrl_we_i & ~run & wdata_i[CR_START];
  // a force-load or a stop write replaces this cycle's normal count
  assign active   = run & tick_i & ~hold_q & ~force_ld & ~stop_wr;
  assign zero     = (cnt_q == '0);
  assign uf_evt   = active & zero;

  always_comb begin
    lat_d = lat_q;
    if (lat_lo_we_i) lat_d[DATA_W-1:0]     = wdata_i;
    if (lat_hi_we_i) lat_d[CNT_W-1:DATA_W] = wdata_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (force_ld)                 cnt_d = lat_q;
    else if (stop_wr)             cnt_d = zero ? cnt_q : cnt_q - CNT_W'(1);
    else if (lat_hi_we_i && !run) cnt_d = {wdata_i, lat_q[DATA_W-1:0]};
    else if (active)              cnt_d = zero ? lat_q : cnt_q - CNT_W'(1);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we_i) begin
      ctrl_d           = wdata_i;
      ctrl_d[CR_FORCE] = 1'b0;
    end
    if (uf_evt && ctrl_q[CR_ONESHOT]) ctrl_d[CR_START] = 1'b0;
  end

  always_comb begin
    tog_d = tog_q;
    if (start_wr)    tog_d = 1'b1;
    else if (uf_evt) tog_d = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '1;
      lat_q  <= '1;
      hold_q <= 1'b0;
      tog_q  <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      lat_q  <= lat_d;
      hold_q <= force_ld;
      tog_q  <= tog_d;
      uf_q   <= uf_evt;
    end
  end

  assign count_o  = cnt_q;
  assign latch_o  = lat_q;
  assign ctrl_o   = ctrl_q;
  assign uf_evt_o = uf_evt;
  assign uf_o     = uf_q;
  assign out_o    = ctrl_q[CR_TOGGLE] ? tog_q : zero;
endmodule

// File: rtl/dit_port_mux.sv
module dit_port_mux #(
  parameter int DATA_W = 8,
  parameter int N_OVR  = 2,
  localparam int BASE  = DATA_W - N_OVR
) (
  input  logic [DATA_W-1:0] port_i,
  input  logic [N_OVR-1:0]  ovr_en_i,
  input  logic [N_OVR-1:0]  ovr_val_i,
  output logic [DATA_W-1:0] port_o
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    if (k >= BASE) begin : g_ovr
      assign port_o[k] = ovr_en_i[k-BASE] ? ovr_val_i[k-BASE] : port_i[k];
    end else begin : g_pass
      assign port_o[k] = port_i[k];
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cnt_i,
  input  logic [DATA_W-1:0] port_i,
  output logic [DATA_W-1:0] port_o,
  output logic              ta_uf_o,
  output logic              ta_shift_o,
  output logic              tb_uf_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              wr, cnt_rise, tick_a, tick_b, shift_q;
  logic [CNT_W-1:0]  count_a, count_b, latch_a, latch_b;
  logic [DATA_W-1:0] ctrl_a, ctrl_b;
  logic              uf_evt_a, uf_evt_b, out_a, out_b;

  assign wr = cs_i & we_i;

  dit_edge_det u_cnt_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (cnt_i),
    .rise_o(cnt_rise)
  );

  assign tick_a = ctrl_a[CR_SRC_LO] ? cnt_rise : 1'b1;

  always_comb begin
    case (b_src(ctrl_b[CR_SRC_HI:CR_SRC_LO]))
      SRC_CLOCK:   tick_b = 1'b1;
      SRC_CASCADE: tick_b = uf_evt_a;
      default:     tick_b = cnt_rise;
    endcase
  end

  dit_timer_core #(.DATA_W(DATA_W)) u_tmr_a (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr && addr_i == ADDR_W'(REG_A_CTL)),
    .lat_lo_we_i(wr && addr_i == ADDR_W'(REG_A_LO)),
    .lat_hi_we_i(wr && addr_i == ADDR_W'(REG_A_HI)),
    .wdata_i    (wdata_i),
    .tick_i     (tick_a),
    .count_o    (count_a),
    .latch_o    (latch_a),
    .ctrl_o     (ctrl_a),
    .uf_evt_o   (uf_evt_a),
    .uf_o       (ta_uf_o),
    .out_o      (out_a)
  );

  dit_timer_core #(.DATA_W(DATA_W)) u_tmr_b (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr && addr_i == ADDR_W'(REG_B_CTL)),
    .lat_lo_we_i(wr && addr_i == ADDR_W'(REG_B_LO)),
    .lat_hi_we_i(wr && addr_i == ADDR_W'(REG_B_HI)),
    .wdata_i    (wdata_i),
    .tick_i     (tick_b),
    .count_o    (count_b),
    .latch_o    (latch_b),
    .ctrl_o     (ctrl_b),
    .uf_evt_o   (uf_evt_b),
    .uf_o       (tb_uf_o),
    .out_o      (out_b)
  );

  // separate flop so the shifter strobe can be routed independently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= 1'b0;
    else         shift_q <= uf_evt_a;
  end
  assign ta_shift_o = shift_q;

  dit_port_mux #(.DATA_W(DATA_W), .N_OVR(2)) u_port (
    .port_i   (port_i),
    .ovr_en_i ({ctrl_b[CR_PORT_EN], ctrl_a[CR_PORT_EN]}),
    .ovr_val_i({out_b, out_a}),
    .port_o   (port_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(REG_A_LO):  rdata_o = count_a[DATA_W-1:0];
      ADDR_W'(REG_A_HI):  rdata_o = count_a[CNT_W-1:DATA_W];
      ADDR_W'(REG_B_LO):  rdata_o = count_b[DATA_W-1:0];
      ADDR_W'(REG_B_HI):  rdata_o = count_b[CNT_W-1:DATA_W];
      ADDR_W'(REG_A_CTL): rdata_o = ctrl_a;
      ADDR_W'(REG_B_CTL): rdata_o = ctrl_b;
      default:            rdata_o = '0;
    endcase
  end
endmodule

module dit_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  cnt_a_i,
  input logic [CNT_W-1:0]  cnt_b_i,
  input logic [CNT_W-1:0]  lat_b_i,
  input logic [DATA_W-1:0] ctrl_a_i,
  input logic [DATA_W-1:0] ctrl_b_i,
  input logic              uf_evt_a_i,
  input logic              uf_evt_b_i,
  input logic              ta_uf_i,
  input logic              ta_shift_i,
  input logic [DATA_W-1:0] port_o_i
);
  logic wr_a_ctl, wr_a_load, wr_b_ctl;
  assign wr_a_ctl  = cs_i && we_i && addr_i == ADDR_W'(14);
  assign wr_a_load = wr_a_ctl || (cs_i && we_i && addr_i == ADDR_W'(5));
  assign wr_b_ctl  = cs_i && we_i && addr_i == ADDR_W'(15);

  p_strobe_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_evt_a_i |=> (ta_uf_i && ta_shift_i));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_evt_b_i |=> cnt_b_i == $past(lat_b_i));

  p_oneshot_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_evt_a_i && ctrl_a_i[3] && !wr_a_ctl) |=> !ctrl_a_i[0]);

  p_idle_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_a_i[0] && !wr_a_load) |=> $stable(cnt_a_i));

  p_pulse_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_b_i[1] && !ctrl_b_i[2]) |-> port_o_i[DATA_W-1] == (cnt_b_i == '0));

  p_cascade_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_b_i[0] && ctrl_b_i[6:5] == 2'b10 && !uf_evt_a_i && !wr_b_ctl)
      |=> $stable(cnt_b_i));
endmodule

bind dual_interval_timer dit_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .cnt_a_i   (count_a),
  .cnt_b_i   (count_b),
  .lat_b_i   (latch_b),
  .ctrl_a_i  (ctrl_a),
  .ctrl_b_i  (ctrl_b),
  .uf_evt_a_i(uf_evt_a),
  .uf_evt_b_i(uf_evt_b),
  .ta_uf_i   (ta_uf_o),
  .ta_shift_i(ta_shift_o),
  .port_o_i  (port_o)
);

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0, cnt_in = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, port_in = '0, port_out;
  logic       ta_uf, ta_shift, tb_uf;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dual_interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt_in), .port_i(port_in),
    .port_o(port_out), .ta_uf_o(ta_uf), .ta_shift_o(ta_shift), .tb_uf_o(tb_uf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a[3:0]; wdata = d[7:0];
    @(posedge clk);
    #1;
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a[3:0];
    #1;
    d = rdata;
    cs = 1'b0;
  endtask

  // negedges from the write edge to the first strobe
  task automatic wait_uf(input bit sel_b, output int k);
    k = 0;
    @(negedge clk);
    while (!(sel_b ? tb_uf : ta_uf) && k < 1000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic cnt_pulse();
    @(negedge clk); cnt_in = 1'b1;
    @(negedge clk); cnt_in = 1'b0;
  endtask

  task automatic t_reset();
    int d;
    rd(4, d); check("R1 cnt A lo", d, 8'hFF);
    rd(5, d); check("R1 cnt A hi", d, 8'hFF);
    rd(6, d); check("R1 cnt B lo", d, 8'hFF);
    rd(7, d); check("R1 cnt B hi", d, 8'hFF);
    rd(14, d); check("R1 ctrl A", d, 0);
    rd(15, d); check("R1 ctrl B", d, 0);
    check("R1 strobes", {ta_uf, ta_shift, tb_uf}, 0);
  endtask

  task automatic t_latch();
    int d;
    wr(4, 8'h12);
    rd(4, d); check("R3 lo write keeps counter", d, 8'hFF);
    wr(5, 8'h34);
    rd(4, d); check("R3 hi write loads lo", d, 8'h12);
    rd(5, d); check("R2 R3 hi write loads hi", d, 8'h34);
    wr(6, 8'h78); wr(7, 8'h56);
    rd(6, d); check("R2 cnt B lo", d, 8'h78);
    rd(7, d); check("R2 cnt B hi", d, 8'h56);
  endtask

  task automatic t_start();
    int k;
    wr(4, 5); wr(5, 0);
    wr(14, 8'h01);
    wait_uf(1'b0, k); check("R4 first underflow", k, 6);
    check("R4 shifter strobe", ta_shift, 1);
    k = 0;
    do begin @(negedge clk); k++; end while (!ta_uf && k < 1000);
    check("R4 period", k, 6);
    @(negedge clk); check("R4 single-cycle strobe", ta_uf, 0);
    wr(14, 8'h00);
  endtask

  task automatic t_force();
    int k, d;
    wr(4, 7);
    wr(14, 8'h11);
    wait_uf(1'b0, k); check("R5 force+start delay", k, 9);
    rd(14, d); check("R2 force bit reads 0", d, 8'h01);
    wr(14, 8'h10);
    rd(4, d); check("R5 R7 stop with force keeps latch", d, 7);
  endtask

  task automatic t_oneshot();
    int k, d, seen;
    wr(4, 4); wr(5, 0);
    wr(14, 8'h09);
    wait_uf(1'b0, k); check("R6 one-shot underflow", k, 5);
    rd(14, d); check("R6 start bit cleared", d, 8'h08);
    seen = 0;
    repeat (20) begin @(negedge clk); if (ta_uf) seen++; end
    check("R6 no further underflow", seen, 0);
    rd(4, d); check("R6 counter reloaded", d, 4);
  endtask

  task automatic t_stop();
    int d;
    wr(4, 100); wr(5, 0);
    wr(14, 8'h01); wr(14, 8'h00);
    rd(4, d); check("R7 extra decrement lo", d, 99);
    rd(5, d); check("R7 extra decrement hi", d, 0);
    wr(4, 0); wr(5, 0);
    wr(14, 8'h01); wr(14, 8'h00);
    @(negedge clk); check("R7 no strobe at zero stop", ta_uf, 0);
    rd(4, d); check("R7 zero stays lo", d, 0);
    rd(5, d); check("R7 zero stays hi", d, 0);
  endtask

  task automatic t_toggle();
    int k;
    port_in = 8'h00;
    wr(4, 3); wr(5, 0);
    wr(14, 8'h07);
    @(negedge clk); check("R8 toggle forced on start", port_out[6], 1);
    k = 0;
    while (!ta_uf && k < 1000) begin @(negedge clk); k++; end
    check("R8 first underflow", k, 4);
    check("R8 toggle inverts", port_out[6], 0);
    @(negedge clk);
    while (!ta_uf && k < 2000) begin @(negedge clk); k++; end
    check("R8 toggle inverts again", port_out[6], 1);
    wr(14, 8'h00);
    port_in = 8'h40;
    @(negedge clk); check("R10 no override when disabled", port_out, 8'h40);
  endtask

  task automatic t_pulse();
    port_in = 8'hFF;
    wr(4, 3); wr(5, 0);
    wr(14, 8'h03);
    @(negedge clk); check("R9 R10 pulse low at count 3", port_out[6], 0);
    repeat (3) @(negedge clk);
    check("R9 pulse high at zero", port_out[6], 1);
    @(negedge clk); check("R9 pulse low after reload", port_out[6], 0);
    wr(14, 8'h00);
    port_in = 8'h00;
    wr(6, 0); wr(7, 0);
    wr(15, 8'h02);
    @(negedge clk); check("R10 timer B drives bit 7", port_out, 8'h80);
    wr(15, 8'h00);
  endtask

  task automatic t_pin();
    int d;
    wr(4, 2); wr(5, 0);
    wr(14, 8'h21);
    repeat (10) @(negedge clk);
    rd(4, d); check("R11 no pin edge no count", d, 2);
    cnt_pulse(); cnt_pulse();
    check("R11 no strobe before zero tick", ta_uf, 0);
    rd(4, d); check("R11 two pin edges", d, 0);
    cnt_pulse();
    check("R11 third pin edge underflows", ta_uf, 1);
    wr(14, 8'h00);
    wr(6, 1); wr(7, 0);
    wr(15, 8'h61);
    cnt_pulse();
    check("R11 B pin mode no early strobe", tb_uf, 0);
    rd(6, d); check("R11 B pin mode counts", d, 0);
    cnt_pulse();
    check("R11 B pin mode underflow", tb_uf, 1);
    wr(15, 8'h00);
  endtask

  task automatic t_cascade();
    int na, at_b, k;
    wr(4, 3); wr(5, 0);
    wr(6, 2); wr(7, 0);
    wr(15, 8'h41);
    wr(14, 8'h01);
    na = 0; at_b = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ta_uf) na++;
      if (tb_uf) begin
        at_b = na;
        check("R12 B strobes with A strobe", ta_uf, 1);
        break;
      end
    end
    check("R12 B underflow on third A underflow", at_b, 3);
    wr(14, 8'h00); wr(15, 8'h00);
    wr(6, 4); wr(7, 0);
    wr(15, 8'h01);
    wait_uf(1'b1, k); check("R4 timer B clock mode", k, 5);
    wr(15, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_start();
    t_force();
    t_oneshot();
    t_stop();
    t_toggle();
    t_pulse();
    t_pin();
    t_cascade();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule